// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers every interrupt source of a processor subsystem into one request to the core. The sources are core exception events, software-interrupt requests, two external pins and a parameterized set of on-chip peripheral lines. Each source belongs to one of five tiers. From lowest to highest these are: a software-only bottom tier, three maskable levels, and a non-maskable top level. Exceptions and software requests have fixed tiers. Pins and peripherals take a maskable level from a programmable two-bit field.

Each cycle the block finds the highest-tier active source, with the lower source index winning a tie. It compares that tier with the core's current priority mask. It raises `irq_req` only when the winner ranks strictly above the mask, or when the winner is non-maskable. Together with the request it presents the winning tier, the source index and a vector address. The vector address is a programmable base plus twice the source index.

Each external pin can be set to one of two modes:
- Level mode: the pin is active while low.
- Falling-edge mode: a falling edge latches a pending flag, which stays set until the core acknowledges that source index.

Top module: `pvic_top`

## Requirements
- R1: The tier code on `irq_lvl` is 1 = software-only bottom tier, 2 = maskable level 0, 3 = level 1, 4 = level 2, 5 = non-maskable level 3. Higher codes always win arbitration.
- R2: Tier 1 is produced only by `swi_lp`, at source index 13. No hardware source ever reaches tier 1.
- R3: Tier 5 sources are `exc_illegal` (index 0), `exc_stack_ovf` (index 1), `exc_misalign` (index 2) and `swi_req[3]` (index 3). They are forwarded whatever the value of `core_mask`.
- R4: Register address 1 holds two-bit fields, where source j uses bits [2j+1:2j]. Pin p is j = p and peripheral k is j = 2 + k. Field value 0 removes the source from arbitration, and values 1, 2, 3 give tiers 2, 3, 4.
- R5: A winner of tier 1 to 4 raises `irq_req` only when its tier code is strictly greater than `core_mask`.
- R6: Among sources of equal tier, the lower index wins. The index map is: exceptions 0 to 2, `swi_req[3]` to `swi_req[0]` at 3 to 6 (tiers 5, 4, 3, 2), pins at 7 and 8, peripheral k at 9 + k, and `swi_lp` at 13.
- R7: `irq_vec` equals the base register (address 0, 16 bits) plus 2 × `irq_src`.
- R8: A pin in level mode (address 2 bit p = 0) is requesting two clocks after it goes low. It stops requesting two clocks after it returns high.
- R9: A pin in edge mode (address 2 bit p = 1) latches a request on a falling edge. The request stays after the pin rises. It is cleared only by `ack_valid` with `ack_src` equal to that pin's index; an acknowledge of another index leaves it set.
- R10: After reset the base, the fields and the modes are zero, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 base, 1 priority fields, 2 pin modes |
| wr_data | input | 16 | Write data |
| periph_irq | input | 4 | Peripheral request lines, active high |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| swi_req | input | 4 | Software requests; bit n is software level n |
| swi_lp | input | 1 | Bottom-tier software request |
| exc_illegal | input | 1 | Illegal-instruction exception |
| exc_stack_ovf | input | 1 | Hardware stack overflow exception |
| exc_misalign | input | 1 | Misaligned data access exception |
| core_mask | input | 3 | Core's current tier code |
| ack_valid | input | 1 | Acknowledge pulse from the core |
| ack_src | input | 4 | Source index being acknowledged |
| irq_req | output | 1 | Combined request to the core |
| irq_lvl | output | 3 | Tier code of the winner |
| irq_src | output | 4 | Source index of the winner |
| irq_vec | output | 16 | Vector address of the winner |

## Verification
The bench first drives single sources alone to establish tier codes, indices and vector addresses. It then drives groups of sources together to check arbitration. One group places equal-tier peripherals beside a fixed software request, which separates index tie-breaking from tier ordering. Another pairs a low-tier winner with mask values just below and equal to its tier, which exposes any off-by-one in the strict comparison. Exceptions under the highest mask confirm non-maskability. Pin tests hold the pin low and then release it: in level mode the request should follow the pin, and in edge mode it should survive the release and clear only on the matching acknowledge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [2:0] {
        TIER_NONE = 3'd0,
        TIER_LP   = 3'd1,
        TIER_L0   = 3'd2,
        TIER_L1   = 3'd3,
        TIER_L2   = 3'd4,
        TIER_L3   = 3'd5
    } tier_e;

    typedef enum logic [1:0] {
        ADDR_BASE = 2'd0,
        ADDR_PRIO = 2'd1,
        ADDR_MODE = 2'd2
    } addr_e;

    localparam int NUM_PINS    = 2;
    localparam int PIN_BASE    = 7;
    localparam int PERIPH_BASE = PIN_BASE + NUM_PINS;

    function automatic tier_e field_to_tier(input logic [1:0] f);
        case (f)
            2'd1:    return TIER_L0;
            2'd2:    return TIER_L1;
            2'd3:    return TIER_L2;
            default: return TIER_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pvic_pin_sense.sv
module pvic_pin_sense (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic req_o
);
    logic sync1, sync2, prev, pend;
    logic fall;

    assign fall = prev & ~sync2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
            pend  <= 1'b0;
        end else begin
            sync1 <= pin_n_i;
            sync2 <= sync1;
            prev  <= sync2;
            if (!edge_mode_i)
                pend <= 1'b0;
            else if (fall)
                pend <= 1'b1;
            else if (clr_i)
                pend <= 1'b0;
        end
    end

    assign req_o = edge_mode_i ? pend : ~sync2;

    // R9: a latched edge survives until acknowledged
    a_r9_pending_held: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && pend && !clr_i) |=> pend);

    // R9: a detected falling edge always sets the flag
    a_r9_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && prev && !sync2) |=> pend);

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int NSRC  = 14,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  pvic_pkg::tier_e  tier_i [NSRC],
    output logic             hit_o,
    output pvic_pkg::tier_e  tier_o,
    output logic [IDX_W-1:0] idx_o
);
    import pvic_pkg::*;

    always_comb begin
        tier_o = TIER_NONE;
        idx_o  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (tier_i[i] != TIER_NONE && tier_i[i] >= tier_o) begin
                tier_o = tier_i[i];
                idx_o  = IDX_W'(i);
            end
        end
        hit_o = (tier_o != TIER_NONE);
    end

    // R1: the chosen source is itself at the reported tier
    a_r1_winner_tier: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (tier_i[idx_o] == tier_o));

endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
    parameter int NP     = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NP-1:0]     periph_irq,
    input  logic [1:0]        ext_pin_n,
    input  logic [3:0]        swi_req,
    input  logic              swi_lp,
    input  logic              exc_illegal,
    input  logic              exc_stack_ovf,
    input  logic              exc_misalign,
    input  logic [2:0]        core_mask,
    input  logic              ack_valid,
    input  logic [$clog2(pvic_pkg::PERIPH_BASE + NP + 1)-1:0] ack_src,
    output logic              irq_req,
    output logic [2:0]        irq_lvl,
    output logic [$clog2(pvic_pkg::PERIPH_BASE + NP + 1)-1:0] irq_src,
    output logic [DATA_W-1:0] irq_vec
);
    import pvic_pkg::*;

    localparam int NSRC   = PERIPH_BASE + NP + 1;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int LP_IDX = NSRC - 1;
    localparam int NPROG  = NUM_PINS + NP;
    localparam int PRIO_W = 2 * NPROG;

    logic [DATA_W-1:0]   base_q;
    logic [PRIO_W-1:0]   prio_q;
    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] pin_req;
    tier_e               tier [NSRC];
    logic                hit;
    tier_e               win_tier;
    logic [IDX_W-1:0]    win_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            prio_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                ADDR_BASE: base_q <= wr_data;
                ADDR_PRIO: prio_q <= wr_data[PRIO_W-1:0];
                ADDR_MODE: mode_q <= wr_data[NUM_PINS-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pvic_pin_sense u_sense (
            .clk         (clk),
            .rst         (rst),
            .pin_n_i     (ext_pin_n[p]),
            .edge_mode_i (mode_q[p]),
            .clr_i       (ack_valid && ack_src == IDX_W'(PIN_BASE + p)),
            .req_o       (pin_req[p])
        );
    end

    always_comb begin
        tier[0] = exc_illegal   ? TIER_L3 : TIER_NONE;
        tier[1] = exc_stack_ovf ? TIER_L3 : TIER_NONE;
        tier[2] = exc_misalign  ? TIER_L3 : TIER_NONE;
        tier[3] = swi_req[3]    ? TIER_L3 : TIER_NONE;
        tier[4] = swi_req[2]    ? TIER_L2 : TIER_NONE;
        tier[5] = swi_req[1]    ? TIER_L1 : TIER_NONE;
        tier[6] = swi_req[0]    ? TIER_L0 : TIER_NONE;
        for (int p = 0; p < NUM_PINS; p++)
            tier[PIN_BASE + p] = pin_req[p] ? field_to_tier(prio_q[2*p +: 2]) : TIER_NONE;
        for (int k = 0; k < NP; k++)
            tier[PERIPH_BASE + k] = periph_irq[k] ? field_to_tier(prio_q[2*(NUM_PINS+k) +: 2])
                                                  : TIER_NONE;
        tier[LP_IDX] = swi_lp ? TIER_LP : TIER_NONE;
    end

    pvic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .tier_i (tier),
        .hit_o  (hit),
        .tier_o (win_tier),
        .idx_o  (win_idx)
    );

    assign irq_req = hit && (win_tier == TIER_L3 || 3'(win_tier) > core_mask);
    assign irq_lvl = 3'(win_tier);
    assign irq_src = win_idx;
    assign irq_vec = base_q + DATA_W'({win_idx, 1'b0});

    // R3: any non-maskable event reaches the core at the top tier
    a_r3_nmi_forward: assert property (@(posedge clk) disable iff (rst)
        (exc_illegal || exc_stack_ovf || exc_misalign || swi_req[3])
            |-> (irq_req && irq_lvl == 3'(TIER_L3)));

    // R2: the bottom tier only ever comes from the low software request
    a_r2_lp_only_soft: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_lvl == 3'(TIER_LP)) |-> (swi_lp && irq_src == IDX_W'(LP_IDX)));

    // R5: a masked core never sees the bottom tier
    a_r5_lp_masked: assert property (@(posedge clk) disable iff (rst)
        (core_mask >= 3'(TIER_LP) && irq_req) |-> (irq_lvl != 3'(TIER_LP)));

    // R10: no request in the cycle after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !irq_req);

endmodule

// File: tb/test_pvic_top.sv
module test_pvic_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  periph_irq;
    logic [1:0]  ext_pin_n;
    logic [3:0]  swi_req;
    logic        swi_lp;
    logic        exc_illegal, exc_stack_ovf, exc_misalign;
    logic [2:0]  core_mask;
    logic        ack_valid;
    logic [3:0]  ack_src;
    logic        irq_req;
    logic [2:0]  irq_lvl;
    logic [3:0]  irq_src;
    logic [15:0] irq_vec;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pvic_top i_pvic_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .periph_irq(periph_irq), .ext_pin_n(ext_pin_n), .swi_req(swi_req), .swi_lp(swi_lp),
        .exc_illegal(exc_illegal), .exc_stack_ovf(exc_stack_ovf), .exc_misalign(exc_misalign),
        .core_mask(core_mask), .ack_valid(ack_valid), .ack_src(ack_src),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_src(irq_src), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_irq(input string req, input int lvl, input int src, input int vec);
        check(req, "irq_req", int'(irq_req), 1);
        check(req, "irq_lvl", int'(irq_lvl), lvl);
        check(req, "irq_src", int'(irq_src), src);
        check(req, "irq_vec", int'(irq_vec), vec);
    endtask

    task automatic quiet_inputs();
        periph_irq = '0; ext_pin_n = 2'b11; swi_req = '0; swi_lp = 1'b0;
        exc_illegal = 1'b0; exc_stack_ovf = 1'b0; exc_misalign = 1'b0;
        core_mask = 3'd0; ack_valid = 1'b0; ack_src = '0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10", "irq_req after reset", int'(irq_req), 0);
        periph_irq = 4'hF; ext_pin_n = 2'b00;
        settle(3);
        check("R10", "fields zero keep pins and peripherals out", int'(irq_req), 0);
        quiet_inputs();
        settle(3);
    endtask

    task automatic t_bottom_tier();
        swi_lp = 1'b1;
        settle(1);
        expect_irq("R2", 1, 13, 26);
        core_mask = 3'd1;
        settle(1);
        check("R5", "bottom tier masked at equal mask", int'(irq_req), 0);
        quiet_inputs();
        settle(1);
    endtask

    task automatic t_program();
        write_reg(2'd0, 16'h1000);
        write_reg(2'd1, 16'h0020);
        periph_irq = 4'b0001;
        swi_lp = 1'b1;
        settle(1);
        expect_irq("R7", 3, 9, 16'h1012);
        core_mask = 3'd3;
        settle(1);
        check("R5", "tier equal to mask held back", int'(irq_req), 0);
        core_mask = 3'd2;
        settle(1);
        check("R5", "tier above mask forwarded", int'(irq_req), 1);
        core_mask = 3'd0;
        write_reg(2'd1, 16'h0000);
        check("R4", "disabled field leaves bottom tier winner", int'(irq_src), 13);
        quiet_inputs();
        settle(1);
    endtask

    task automatic t_ties();
        write_reg(2'd1, 16'h03E0);
        periph_irq = 4'b0111;
        settle(1);
        expect_irq("R6", 4, 10, 16'h1014);
        swi_req = 4'b0101;
        settle(1);
        expect_irq("R6", 4, 4, 16'h1008);
        swi_req = 4'b0001;
        settle(1);
        check("R1", "level 2 beats level 0", int'(irq_src), 10);
        quiet_inputs();
        write_reg(2'd1, 16'h0000);
    endtask

    task automatic t_nonmaskable();
        core_mask = 3'd7;
        swi_req = 4'b0100;
        settle(1);
        check("R5", "level 2 masked by high mask", int'(irq_req), 0);
        exc_misalign = 1'b1; swi_req = 4'b1100;
        settle(1);
        expect_irq("R3", 5, 2, 16'h1004);
        exc_illegal = 1'b1;
        settle(1);
        expect_irq("R3", 5, 0, 16'h1000);
        quiet_inputs();
        settle(1);
    endtask

    task automatic t_level_pin();
        write_reg(2'd1, 16'h0001);
        write_reg(2'd2, 16'h0000);
        ext_pin_n[0] = 1'b0;
        settle(1);
        check("R8", "not yet through synchronizer", int'(irq_req), 0);
        settle(1);
        expect_irq("R8", 2, 7, 16'h100E);
        ext_pin_n[0] = 1'b1;
        settle(2);
        check("R8", "drops after pin high", int'(irq_req), 0);
        quiet_inputs();
    endtask

    task automatic t_edge_pin();
        write_reg(2'd1, 16'h0004);
        write_reg(2'd2, 16'h0002);
        ext_pin_n[1] = 1'b0;
        settle(3);
        ext_pin_n[1] = 1'b1;
        settle(4);
        expect_irq("R9", 2, 8, 16'h1010);
        ack_valid = 1'b1; ack_src = 4'd7;
        settle(1);
        ack_valid = 1'b0;
        check("R9", "other index ack ignored", int'(irq_req), 1);
        ack_valid = 1'b1; ack_src = 4'd8;
        settle(1);
        ack_valid = 1'b0;
        check("R9", "matching ack clears", int'(irq_req), 0);
        quiet_inputs();
    endtask

    initial begin
        quiet_inputs();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rst = 1'b1;
        settle(3);
        rst = 1'b0;
        settle(1);
        t_reset();
        t_bottom_tier();
        t_program();
        t_ties();
        t_nonmaskable();
        t_level_pin();
        t_edge_pin();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule